// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block is a byte-wide configuration window that takes up two host I/O locations. Location 0 is the index port and location 1 is the data port. The host selects a configuration register by writing its number to the index port, then reads or writes that register through the data port.

The window starts locked. The host opens it by writing the entry key twice in a row to the index port. It closes the window again by writing the exit key to the index port. While the window is open, a few global registers give the identification bytes and a logical-device select. Every other register belongs to a bank, one bank per logical device, and the select value picks which bank those indices reach. Each bank holds an activate bit and a 16-bit base address. These go straight out to downstream logic.

Decoding of the full host address, and any function behind the logical devices, are left to the surrounding logic.

Top module: `cfg_port_top`

## Requirements
- R1: After reset the window is locked, `rdata_o` is 0x00, the device select is 0, and every bank has its activate bit and base address cleared.
- R2: The window opens only when index-port writes carry 0x87 twice in a row. `unlocked_o` rises on the clock edge that accepts the second of these writes.
- R3: Between the two key writes, an index-port write of any value other than 0x87 discards the first key. A fresh pair of 0x87 writes is then needed.
- R4: While the window is open, an index-port write of 0xAA locks it again, and `unlocked_o` falls on that edge.
- R5: While the window is locked, data-port writes change no register, and reads of either port return 0xFF.
- R6: While the window is open, an index-port write other than 0xAA loads the index register, and an index-port read returns that index.
- R7: Index 0x07 is the device select. It can be read and written, and its value drives `ldn_o`.
- R8: Identifiers are read high byte first: the device identifier at 0x20 (high) and 0x21 (low), the revision at 0x22, and the manufacturer identifier 0x1934 at 0x23 (high) and 0x24 (low). Writes to 0x20 through 0x24 have no effect.
- R9: In the bank chosen by the select value, bit 0 of index 0x30 is the activate bit (bits 7:1 read 0), index 0x60 is the high byte of the base address, and index 0x61 is the low byte. These drive `dev_en_o[n]` and `dev_base_o[16n+15:16n]`, and the other banks are left untouched.
- R10: When the select value is not below NUM_DEV, indices 0x30, 0x60 and 0x61 read 0x00, and writes to them are ignored.
- R11: Any index that is not implemented reads 0x00.
- R12: A read strobe latches the read value into `rdata_o` on the same clock edge. `rdata_o` holds that value until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 1 | 0 selects the index port, 1 selects the data port |
| wr_i | input | 1 | Write strobe, one cycle |
| rd_i | input | 1 | Read strobe, one cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| unlocked_o | output | 1 | High while the configuration window is open |
| ldn_o | output | 8 | Current logical-device select |
| dev_en_o | output | NUM_DEV | Activate bit of each bank |
| dev_base_o | output | 16*NUM_DEV | Base address of each bank, bank n at bits 16n+15:16n |

## Verification
The bench goes after broken key sequences. It sends a stray byte between the two 0x87 writes, which a design that does not reset its key progress would take as an unlock. It writes through the data port while the window is locked. A design that ignores the lock would change `ldn_o` or a bank, and a design that fails to mask reads would return real data instead of 0xFF. It steps the select value through each bank and past NUM_DEV. A design with faulty bank decoding would leak a write into the wrong bank or answer for a device that does not exist. It also writes to the identifier bytes and reads indices that are not implemented, where a design that decodes too loosely would return nonzero data.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam logic [7:0] KEY_UNLOCK  = 8'h87;
  localparam logic [7:0] KEY_LOCK    = 8'hAA;
  localparam logic [7:0] IDX_LDN     = 8'h07;
  localparam logic [7:0] IDX_DID_HI  = 8'h20;
  localparam logic [7:0] IDX_DID_LO  = 8'h21;
  localparam logic [7:0] IDX_REV     = 8'h22;
  localparam logic [7:0] IDX_MID_HI  = 8'h23;
  localparam logic [7:0] IDX_MID_LO  = 8'h24;
  localparam logic [7:0] IDX_ACT     = 8'h30;
  localparam logic [7:0] IDX_BASE_HI = 8'h60;
  localparam logic [7:0] IDX_BASE_LO = 8'h61;
  localparam logic [7:0] BUS_IDLE    = 8'hFF;

  typedef enum logic [1:0] {KS_LOCKED, KS_HALF, KS_OPEN} key_state_e;
endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
  import cfgp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_wr_i,
  input  logic [7:0] wdata_i,
  output logic       open_o,
  output logic       idx_load_o
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      KS_LOCKED: if (idx_wr_i && wdata_i == KEY_UNLOCK) state_d = KS_HALF;
      KS_HALF:   if (idx_wr_i) state_d = (wdata_i == KEY_UNLOCK) ? KS_OPEN : KS_LOCKED;
      KS_OPEN:   if (idx_wr_i && wdata_i == KEY_LOCK) state_d = KS_LOCKED;
      default:   state_d = KS_LOCKED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= KS_LOCKED;
    else         state_q <= state_d;
  end

  assign open_o     = (state_q == KS_OPEN);
  assign idx_load_o = open_o && idx_wr_i && (wdata_i != KEY_LOCK);

  AST_TWO_KEYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> $past(idx_wr_i && wdata_i == KEY_UNLOCK)); // R2
  AST_KEY_BREAK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == KS_HALF && idx_wr_i && wdata_i != KEY_UNLOCK) |=> !open_o); // R3
  AST_RELOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_o && idx_wr_i && wdata_i == KEY_LOCK) |=> !open_o); // R4
endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs
  import cfgp_pkg::*;
#(
  parameter logic [15:0] DEV_ID  = 16'h0A52,
  parameter logic [7:0]  DEV_REV = 8'h11,
  parameter logic [15:0] MFR_ID  = 16'h1934
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_load_i,
  input  logic       data_wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] idx_o,
  output logic [7:0] ldn_o,
  output logic [7:0] rd_byte_o,
  output logic       hit_o
);
  logic [7:0] idx_q, ldn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      ldn_q <= '0;
    end else begin
      if (idx_load_i) idx_q <= wdata_i;
      if (data_wr_i && idx_q == IDX_LDN) ldn_q <= wdata_i;
    end
  end

  always_comb begin
    hit_o     = 1'b1;
    rd_byte_o = 8'h00;
    unique case (idx_q)
      IDX_LDN:    rd_byte_o = ldn_q;
      IDX_DID_HI: rd_byte_o = DEV_ID[15:8];
      IDX_DID_LO: rd_byte_o = DEV_ID[7:0];
      IDX_REV:    rd_byte_o = DEV_REV;
      IDX_MID_HI: rd_byte_o = MFR_ID[15:8];
      IDX_MID_LO: rd_byte_o = MFR_ID[7:0];
      default:    hit_o = 1'b0;
    endcase
  end

  assign idx_o = idx_q;
  assign ldn_o = ldn_q;

  AST_LDN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(data_wr_i && idx_q == IDX_LDN) |=> $stable(ldn_q)); // R7
  AST_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idx_load_i |=> $stable(idx_q)); // R6
endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
  import cfgp_pkg::*;
#(
  parameter int NUM_DEV = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   data_wr_i,
  input  logic [7:0]             idx_i,
  input  logic [7:0]             ldn_i,
  input  logic [7:0]             wdata_i,
  output logic [NUM_DEV-1:0]     dev_en_o,
  output logic [16*NUM_DEV-1:0]  dev_base_o,
  output logic [7:0]             rd_byte_o,
  output logic                   hit_o
);
  localparam int LDN_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

  logic [LDN_W-1:0] sel;
  logic             ldn_ok;
  logic             en_q   [NUM_DEV];
  logic [15:0]      base_q [NUM_DEV];

  assign sel    = ldn_i[LDN_W-1:0];
  assign ldn_ok = ({24'd0, ldn_i} < 32'(NUM_DEV));

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_bank
    logic wr_me;
    assign wr_me = data_wr_i && ldn_ok && (sel == LDN_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q[g]   <= 1'b0;
        base_q[g] <= '0;
      end else if (wr_me) begin
        if (idx_i == IDX_ACT)     en_q[g]         <= wdata_i[0];
        if (idx_i == IDX_BASE_HI) base_q[g][15:8] <= wdata_i;
        if (idx_i == IDX_BASE_LO) base_q[g][7:0]  <= wdata_i;
      end
    end

    assign dev_en_o[g]           = en_q[g];
    assign dev_base_o[g*16 +: 16] = base_q[g];
  end

  always_comb begin
    hit_o     = 1'b1;
    rd_byte_o = 8'h00;
    unique case (idx_i)
      IDX_ACT:     if (ldn_ok) rd_byte_o = {7'd0, en_q[sel]};
      IDX_BASE_HI: if (ldn_ok) rd_byte_o = base_q[sel][15:8];
      IDX_BASE_LO: if (ldn_ok) rd_byte_o = base_q[sel][7:0];
      default:     hit_o = 1'b0;
    endcase
  end

  AST_NO_STRAY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_wr_i |=> ($stable(dev_en_o) && $stable(dev_base_o))); // R5
  AST_BAD_LDN_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ldn_ok |=> ($stable(dev_en_o) && $stable(dev_base_o))); // R10
endmodule

// File: rtl/cfg_port_top.sv
module cfg_port_top
  import cfgp_pkg::*;
#(
  parameter int          NUM_DEV = 4,
  parameter logic [15:0] DEV_ID  = 16'h0A52,
  parameter logic [7:0]  DEV_REV = 8'h11,
  parameter logic [15:0] MFR_ID  = 16'h1934
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  addr_i,
  input  logic                  wr_i,
  input  logic                  rd_i,
  input  logic [7:0]            wdata_i,
  output logic [7:0]            rdata_o,
  output logic                  unlocked_o,
  output logic [7:0]            ldn_o,
  output logic [NUM_DEV-1:0]    dev_en_o,
  output logic [16*NUM_DEV-1:0] dev_base_o
);
  logic       open, idx_load, idx_wr, data_wr;
  logic [7:0] idx, ldn, g_byte, d_byte, rd_val, rdata_q;
  logic       g_hit, d_hit;

  assign idx_wr  = wr_i && !addr_i;
  assign data_wr = wr_i && addr_i && open;

  cfg_key_fsm u_key (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idx_wr_i   (idx_wr),
    .wdata_i    (wdata_i),
    .open_o     (open),
    .idx_load_o (idx_load)
  );

  cfg_global_regs #(.DEV_ID(DEV_ID), .DEV_REV(DEV_REV), .MFR_ID(MFR_ID)) u_glob (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idx_load_i (idx_load),
    .data_wr_i  (data_wr),
    .wdata_i    (wdata_i),
    .idx_o      (idx),
    .ldn_o      (ldn),
    .rd_byte_o  (g_byte),
    .hit_o      (g_hit)
  );

  cfg_dev_bank #(.NUM_DEV(NUM_DEV)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .data_wr_i  (data_wr),
    .idx_i      (idx),
    .ldn_i      (ldn),
    .wdata_i    (wdata_i),
    .dev_en_o   (dev_en_o),
    .dev_base_o (dev_base_o),
    .rd_byte_o  (d_byte),
    .hit_o      (d_hit)
  );

  always_comb begin
    if (!open)        rd_val = BUS_IDLE;
    else if (!addr_i) rd_val = idx;
    else if (g_hit)   rd_val = g_byte;
    else if (d_hit)   rd_val = d_byte;
    else              rd_val = 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= 8'h00;
    else if (rd_i) rdata_q <= rd_val;
  end

  assign rdata_o    = rdata_q;
  assign unlocked_o = open;
  assign ldn_o      = ldn;

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o)); // R12
  AST_LOCKED_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !unlocked_o) |=> (rdata_o == BUS_IDLE)); // R5
endmodule

// File: tb/sim_cfg_port_top.sv
module sim_cfg_port_top;
  localparam int          CLK_PERIOD = 10;
  localparam int          N          = 4;
  localparam logic [15:0] DID        = 16'h0A52;
  localparam logic [7:0]  REV        = 8'h11;
  localparam logic [15:0] MID        = 16'h1934;

  logic            clk = 1'b0, rst_n = 1'b0;
  logic            addr = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0]      wdata = '0;
  logic [7:0]      rdata, ldn_out;
  logic            unl;
  logic [N-1:0]    den;
  logic [16*N-1:0] dbase;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // bench model
  int          m_stage = 0;
  logic [7:0]  m_idx = 0, m_ldn = 0;
  logic        m_en   [N];
  logic [15:0] m_base [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_port_top #(.NUM_DEV(N), .DEV_ID(DID), .DEV_REV(REV), .MFR_ID(MID)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .unlocked_o(unl), .ldn_o(ldn_out),
    .dev_en_o(den), .dev_base_o(dbase)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_wr(logic a, logic [7:0] d);
    if (!a) begin
      case (m_stage)
        0: m_stage = (d == 8'h87) ? 1 : 0;
        1: m_stage = (d == 8'h87) ? 2 : 0;
        default: if (d == 8'hAA) m_stage = 0; else m_idx = d;
      endcase
    end else if (m_stage == 2) begin
      if (m_idx == 8'h07) m_ldn = d;
      else if (m_ldn < N) begin
        if (m_idx == 8'h30) m_en[m_ldn]         = d[0];
        if (m_idx == 8'h60) m_base[m_ldn][15:8] = d;
        if (m_idx == 8'h61) m_base[m_ldn][7:0]  = d;
      end
    end
  endtask

  function automatic logic [7:0] exp_rd(logic a);
    if (m_stage != 2) return 8'hFF;
    if (!a) return m_idx;
    case (m_idx)
      8'h07: return m_ldn;
      8'h20: return DID[15:8];
      8'h21: return DID[7:0];
      8'h22: return REV;
      8'h23: return MID[15:8];
      8'h24: return MID[7:0];
      8'h30: return (m_ldn < N) ? {7'd0, m_en[m_ldn]} : 8'h00;
      8'h60: return (m_ldn < N) ? m_base[m_ldn][15:8] : 8'h00;
      8'h61: return (m_ldn < N) ? m_base[m_ldn][7:0] : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string rtag(logic a);
    if (m_stage != 2) return "R5";
    if (!a) return "R6";
    case (m_idx)
      8'h07: return "R7";
      8'h20, 8'h21, 8'h22, 8'h23, 8'h24: return "R8";
      8'h30, 8'h60, 8'h61: return (m_ldn < N) ? "R9" : "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic bus_wr(logic a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
    model_wr(a, d);
  endtask

  task automatic bus_rd(logic a, string tag);
    logic [7:0] e;
    e = exp_rd(a);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd = 1'b0;
    check(tag, rdata, e);
  endtask

  task automatic check_outs(string tag);
    for (int g = 0; g < N; g++) begin
      check(tag, den[g], m_en[g]);
      check(tag, dbase[g*16 +: 16], m_base[g]);
    end
    check(tag, ldn_out, m_ldn);
    check("R2", unl, m_stage == 2);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic logic [7:0] pick_idx();
    case ($urandom % 12)
      0: return 8'h07;  1: return 8'h20;  2: return 8'h21;  3: return 8'h22;
      4: return 8'h23;  5: return 8'h24;  6: return 8'h30;  7: return 8'h60;
      8: return 8'h61;  9: return 8'h87;  10: return 8'hAA;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    logic [7:0] hold;
    void'($urandom(32'd4242));
    for (int g = 0; g < N; g++) begin m_en[g] = 0; m_base[g] = 0; end
    #(CLK_PERIOD * 3);
    @(negedge clk);
    // R1 reset state
    check("R1", rdata, 8'h00);
    check("R1", unl, 1'b0);
    check("R1", ldn_out, 8'h00);
    check("R1", den, '0);
    check("R1", dbase, '0);
    rst_n = 1'b1;

    // R5 locked: writes ignored, reads 0xFF
    bus_wr(0, 8'h07);
    bus_wr(1, 8'h03);
    check("R5", ldn_out, 8'h00);
    bus_rd(1, "R5");
    bus_rd(0, "R5");

    // R3 broken key, then R2 clean pair
    bus_wr(0, 8'h87);
    bus_wr(0, 8'h55);
    bus_wr(0, 8'h87);
    check("R3", unl, 1'b0);
    bus_wr(0, 8'h87);
    check("R2", unl, 1'b1);

    // R6 index readback, R8 identifiers and read-only
    bus_wr(0, 8'h23);
    bus_rd(0, "R6");
    check("R6", rdata, 8'h23);
    bus_rd(1, "R8");
    check("R8", rdata, 8'h19);
    bus_wr(1, 8'h00);
    bus_rd(1, "R8");
    for (int i = 8'h20; i <= 8'h24; i++) begin
      bus_wr(0, 8'(i));
      bus_wr(1, 8'h5A);
      bus_rd(1, "R8");
    end

    // R7 select, R9 banked registers
    bus_wr(0, 8'h07); bus_wr(1, 8'h02);
    check("R7", ldn_out, 8'h02);
    bus_rd(1, "R7");
    bus_wr(0, 8'h30); bus_wr(1, 8'hFF);
    bus_rd(1, "R9");
    check("R9", rdata, 8'h01);
    bus_wr(0, 8'h60); bus_wr(1, 8'hAB);
    bus_wr(0, 8'h61); bus_wr(1, 8'hCD);
    check("R9", dbase[47:32], 16'hABCD);
    check_outs("R9");
    bus_wr(0, 8'h07); bus_wr(1, 8'h00);
    bus_wr(0, 8'h30);
    bus_rd(1, "R9");
    check("R9", rdata, 8'h00);

    // R10 select out of range
    bus_wr(0, 8'h07); bus_wr(1, 8'h09);
    bus_wr(0, 8'h30); bus_wr(1, 8'h01);
    bus_rd(1, "R10");
    check_outs("R10");

    // R11 unimplemented index
    bus_wr(0, 8'h45); bus_wr(1, 8'h77);
    bus_rd(1, "R11");

    // R12 rdata holds without a strobe
    bus_wr(0, 8'h22);
    bus_rd(1, "R12");
    hold = rdata;
    bus_wr(0, 8'h23);
    repeat (3) @(negedge clk);
    check("R12", rdata, hold);

    // R4 relock
    bus_wr(0, 8'hAA);
    check("R4", unl, 1'b0);
    bus_rd(1, "R4");
    bus_rd(0, "R4");

    // random phase
    for (int it = 0; it < 500; it++) begin
      int r;
      r = $urandom % 10;
      if (r < 4) bus_wr(0, pick_idx());
      else if (r < 7) bus_wr(1, (m_idx == 8'h07) ? 8'($urandom % 6) : 8'($urandom));
      else begin
        logic a;
        a = 1'($urandom);
        bus_rd(a, rtag(a));
      end
      if (it % 25 == 0 && m_stage != 2) begin
        bus_wr(0, 8'h87); bus_wr(0, 8'h87);
      end
      check_outs("R9");
    end

    finished = 1;
    finish_run();
  end
endmodule